// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block is the start-up stage of an SDRAM controller. After reset it owns the memory's command pins and walks the device from power-on to a usable state. First it keeps the command bus idle, with clock enable and the data mask both high, for a quiet period. The length of that period is set in microseconds and converted to clock cycles from a clock-frequency parameter. It then closes all banks with a precharge-all. Next it loads the mode register from a supplied mode word. Last it issues a fixed number of auto-refresh commands.

Each command is followed by idle cycles for its recovery time: row precharge, mode-set recovery or refresh cycle time, each given as a cycle count. Once the last refresh has recovered, the block raises a ready flag and releases the data mask. From then on it leaves the bus idle, so the normal access logic can take over. A reset at any point restarts the whole sequence from the quiet period.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are: command idle (`sd_cs_n,sd_ras_n,sd_cas_n,sd_we_n` = 0,1,1,1), `sd_cke`=1, `sd_dqm`=1, `sd_addr`=0 and `init_done`=0.
- R2: After `rst_n` rises, the command stays idle for at least PAUSE_CYC = CLK_MHZ*PAUSE_US cycles. The first non-idle command appears no later than PAUSE_CYC+4 cycles after the release.
- R3: `sd_cke` is high in every cycle. `sd_dqm` is high in every cycle in which `init_done` is low.
- R4: The first non-idle command is precharge-all: pins 0,0,1,0, with `sd_addr` bit 10 set and every other address bit zero.
- R5: The second command is mode-register set: pins 0,0,0,0, with `sd_addr` equal to `mode_word`. It comes exactly T_RP cycles after the precharge.
- R6: The cycle after the mode-register set is idle. The first auto-refresh comes exactly T_MRD cycles after the mode-register set.
- R7: Exactly REF_COUNT auto-refresh commands (pins 0,0,0,1, `sd_addr`=0) follow the mode-register set, each exactly T_RFC cycles after the previous one. No other command is issued.
- R8: `init_done` rises exactly T_RFC cycles after the last auto-refresh, and not before.
- R9: Once high, `init_done` stays high until reset. While it is high, `sd_dqm` is low and the command is idle.
- R10: A reset asserted in the middle of the sequence returns the outputs to the R1 state. After release, the complete sequence runs again from the quiet period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_word | input | ADDR_W | Value driven on the address bus during the mode-register set |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_dqm | output | 1 | Data mask, high keeps the data bus undriven |
| sd_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Memory ready for normal access |

## Verification
Every cycle, the assertions check a set of safety properties:
- the command stays idle during the quiet window, and the first command is a correctly addressed precharge-all;
- commands are never closer together than their recovery time, and an idle cycle follows every mode-register set;
- the pin holds on clock enable and data mask are kept;
- the ready flag never drops and leaves the bus idle.

Only the bench scenarios can show the exact positions of commands and the exact number of refreshes. They also show that the mode word arrives on the address bus, that the ready flag appears at the exact cycle, and that an abort by reset in mid-sequence leads to a full, clean restart.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Pin order {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MODE_SET  = 4'b0000,
    CMD_REFRESH   = 4'b0001,
    CMD_PRECHARGE = 4'b0010,
    CMD_IDLE      = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_QUIET,
    ST_PRECHG,
    ST_PRECHG_WAIT,
    ST_MODE,
    ST_MODE_WAIT,
    ST_REFRESH,
    ST_REFRESH_WAIT,
    ST_READY
  } init_state_e;

endpackage

// File: rtl/sdram_rst_sync.sv
module sdram_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int TMR_W   = 16,
  parameter int RST_VAL = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  input  logic             en,
  output logic             zero
);
  logic [TMR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                       cnt_d = load_val;
    else if (en && (cnt_q != '0))   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= TMR_W'(RST_VAL);
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int T_RP      = 3,
  parameter int T_MRD     = 2,
  parameter int T_RFC     = 9,
  parameter int REF_COUNT = 8,
  parameter int TMR_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [TMR_W-1:0] tmr_val,
  output logic             tmr_en,
  output init_state_e      state
);
  localparam int REF_W = $clog2(REF_COUNT + 1);

  init_state_e      state_q, state_d;
  logic [REF_W-1:0] refs_q, refs_d;

  always_comb begin
    state_d  = state_q;
    refs_d   = refs_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_en   = 1'b0;
    unique case (state_q)
      ST_QUIET: begin
        tmr_en = 1'b1;
        if (tmr_zero) state_d = ST_PRECHG;
      end
      ST_PRECHG: begin
        // wait states = recovery - 1, next command lands exactly on recovery
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(T_RP - 2);
        state_d  = ST_PRECHG_WAIT;
      end
      ST_PRECHG_WAIT: begin
        tmr_en = 1'b1;
        if (tmr_zero) state_d = ST_MODE;
      end
      ST_MODE: begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(T_MRD - 2);
        state_d  = ST_MODE_WAIT;
      end
      ST_MODE_WAIT: begin
        tmr_en = 1'b1;
        if (tmr_zero) state_d = ST_REFRESH;
      end
      ST_REFRESH: begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(T_RFC - 2);
        refs_d   = refs_q - 1'b1;
        state_d  = ST_REFRESH_WAIT;
      end
      ST_REFRESH_WAIT: begin
        tmr_en = 1'b1;
        if (tmr_zero) state_d = (refs_q == '0) ? ST_READY : ST_REFRESH;
      end
      ST_READY: state_d = ST_READY;
      default:  state_d = ST_QUIET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_QUIET;
      refs_q  <= REF_W'(REF_COUNT);
    end else begin
      state_q <= state_d;
      refs_q  <= refs_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/sdram_cmd_out.sv
module sdram_cmd_out
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  init_state_e       state,
  input  logic [ADDR_W-1:0] mode_word,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_cke,
  output logic              sd_dqm,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done
);
  sd_cmd_e           cmd_d, cmd_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic              ready_d, ready_q;
  logic              cke_q;

  always_comb begin
    cmd_d   = CMD_IDLE;
    addr_d  = '0;
    ready_d = 1'b0;
    unique case (state)
      ST_PRECHG: begin
        cmd_d          = CMD_PRECHARGE;
        addr_d[AP_BIT] = 1'b1;
      end
      ST_MODE: begin
        cmd_d  = CMD_MODE_SET;
        addr_d = mode_word;
      end
      ST_REFRESH: cmd_d   = CMD_REFRESH;
      ST_READY:   ready_d = 1'b1;
      default:    cmd_d   = CMD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= CMD_IDLE;
      addr_q  <= '0;
      ready_q <= 1'b0;
      cke_q   <= 1'b1;
    end else begin
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      ready_q <= ready_d;
      cke_q   <= 1'b1;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_addr   = addr_q;
  assign sd_cke    = cke_q;
  assign sd_dqm    = ~ready_q;
  assign init_done = ready_q;
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ   = 125,
  parameter int PAUSE_US  = 200,
  parameter int T_RP      = 3,
  parameter int T_MRD     = 2,
  parameter int T_RFC     = 9,
  parameter int REF_COUNT = 8,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mode_word,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_cke,
  output logic              sd_dqm,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done
);
  localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
  localparam int TMR_W     = $clog2(PAUSE_CYC + 1);

  logic             srst_n;
  logic             tmr_load, tmr_en, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  init_state_e      state;

  sdram_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  sdram_init_timer #(
    .TMR_W   (TMR_W),
    .RST_VAL (PAUSE_CYC - 1)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .en       (tmr_en),
    .zero     (tmr_zero)
  );

  sdram_init_fsm #(
    .T_RP      (T_RP),
    .T_MRD     (T_MRD),
    .T_RFC     (T_RFC),
    .REF_COUNT (REF_COUNT),
    .TMR_W     (TMR_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (srst_n),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .tmr_en   (tmr_en),
    .state    (state)
  );

  sdram_cmd_out #(
    .ADDR_W (ADDR_W),
    .AP_BIT (AP_BIT)
  ) u_out (
    .clk       (clk),
    .rst_n     (srst_n),
    .state     (state),
    .mode_word (mode_word),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_cke    (sd_cke),
    .sd_dqm    (sd_dqm),
    .sd_addr   (sd_addr),
    .init_done (init_done)
  );
endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
  parameter int PAUSE_CYC = 25000,
  parameter int T_RP      = 3,
  parameter int T_MRD     = 2,
  parameter int T_RFC     = 9,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic              sd_cke,
  input logic              sd_dqm,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              init_done
);
  localparam logic [3:0] C_IDLE = 4'b0111;
  localparam logic [3:0] C_PRE  = 4'b0010;
  localparam logic [3:0] C_MRS  = 4'b0000;
  localparam logic [ADDR_W-1:0] AP_ADDR = ADDR_W'(1) << AP_BIT;

  logic [3:0]  cmd;
  int unsigned quiet_q;
  logic        seen_q;
  logic [15:0] gap_q, need_q;

  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q <= 0;
      seen_q  <= 1'b0;
      gap_q   <= '0;
      need_q  <= '0;
    end else begin
      if (quiet_q < PAUSE_CYC) quiet_q <= quiet_q + 1;
      if (cmd != C_IDLE) begin
        seen_q <= 1'b1;
        gap_q  <= 16'd1;
        need_q <= (cmd == C_PRE) ? 16'(T_RP) : (cmd == C_MRS) ? 16'(T_MRD) : 16'(T_RFC);
      end else if (gap_q != 16'hFFFF) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  AST_QUIET_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_q < PAUSE_CYC) |-> (cmd == C_IDLE)); // R2
  AST_CKE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cke); // R3
  AST_DQM_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> sd_dqm); // R3
  AST_FIRST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_q && cmd != C_IDLE) |-> (cmd == C_PRE && sd_addr == AP_ADDR)); // R4
  AST_MIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && cmd != C_IDLE) |-> (gap_q >= need_q)); // R5
  AST_IDLE_AFTER_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_MRS) |=> (cmd == C_IDLE)); // R6
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R9
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cmd == C_IDLE && !sd_dqm)); // R9
endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
  .PAUSE_CYC (PAUSE_CYC),
  .T_RP      (T_RP),
  .T_MRD     (T_MRD),
  .T_RFC     (T_RFC),
  .ADDR_W    (ADDR_W),
  .AP_BIT    (AP_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sd_cs_n   (sd_cs_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .sd_cke    (sd_cke),
  .sd_dqm    (sd_dqm),
  .sd_addr   (sd_addr),
  .init_done (init_done)
);

// File: tb/sim_sdram_pwrup_seq.sv
`timescale 1ns/1ps
module sim_sdram_pwrup_seq;
  localparam int CLK_MHZ = 125, PAUSE_US = 200;
  localparam int T_RP = 3, T_MRD = 2, T_RFC = 9, REF_COUNT = 8;
  localparam int ADDR_W = 13, AP_BIT = 10;
  localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
  localparam int N_CMDS = 2 + REF_COUNT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] mode_word = '0;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, sd_dqm, init_done;
  logic [ADDR_W-1:0] sd_addr;

  always #4 clk = ~clk;

  sdram_pwrup_seq #(
    .CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .T_RP(T_RP), .T_MRD(T_MRD),
    .T_RFC(T_RFC), .REF_COUNT(REF_COUNT), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_cke(sd_cke), .sd_dqm(sd_dqm), .sd_addr(sd_addr), .init_done(init_done)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected command per position and its required distance from the previous one
  function automatic logic [3:0] exp_cmd(input int i);
    if (i == 0) return 4'b0010;
    if (i == 1) return 4'b0000;
    return 4'b0001;
  endfunction
  function automatic int exp_gap(input int i);
    if (i == 1) return T_RP;
    if (i == 2) return T_MRD;
    return T_RFC;
  endfunction
  function automatic logic [ADDR_W-1:0] exp_addr(input int i, input logic [ADDR_W-1:0] mw);
    if (i == 0) return ADDR_W'(1) << AP_BIT;
    if (i == 1) return mw;
    return '0;
  endfunction

  // monitor
  bit mon_on = 0;
  int cyc, ev_n, done_cyc;
  int ev_cyc [0:31];
  logic [3:0] ev_cmd [0:31];
  logic [ADDR_W-1:0] ev_addr [0:31];
  bit cke_bad, dqm_bad, done_fell, cmd_after_done, mode_not_idle, prev_mode;

  task automatic mon_clear();
    cyc = 0; ev_n = 0; done_cyc = -1;
    cke_bad = 0; dqm_bad = 0; done_fell = 0; cmd_after_done = 0;
    mode_not_idle = 0; prev_mode = 0;
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      logic [3:0] c;
      cyc++;
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (!sd_cke) cke_bad = 1;
      if (sd_dqm == init_done) dqm_bad = 1;
      if (prev_mode && c != 4'b0111) mode_not_idle = 1;
      prev_mode = (c == 4'b0000);
      if (done_cyc >= 0 && !init_done) done_fell = 1;
      if (done_cyc >= 0 && c != 4'b0111) cmd_after_done = 1;
      if (init_done && done_cyc < 0) done_cyc = cyc;
      if (c != 4'b0111) begin
        if (ev_n < 32) begin
          ev_cyc[ev_n] = cyc; ev_cmd[ev_n] = c; ev_addr[ev_n] = sd_addr;
        end
        ev_n++;
      end
    end
  end

  task automatic check_reset_state(input string req);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, req, "reset cmd",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
    chk(sd_cke && sd_dqm, req, "reset cke/dqm", {sd_cke, sd_dqm}, 2'b11);
    chk(sd_addr == '0, req, "reset addr", sd_addr, 0);
    chk(!init_done, req, "reset init_done", init_done, 0);
  endtask

  task automatic apply_reset();
    mon_on = 0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat ($urandom_range(2, 9)) @(negedge clk);
    check_reset_state("R1");
    mode_word = ADDR_W'($urandom);
    mon_clear();
    rst_n = 1'b1;
    mon_on = 1;
  endtask

  task automatic full_run();
    int lim;
    int ref_bad;
    lim = 0;
    while (done_cyc < 0 && lim < PAUSE_CYC + 500) begin
      @(negedge clk); lim++;
    end
    repeat (30) @(negedge clk);
    chk(ev_n == N_CMDS, "R7", "command count", ev_n, N_CMDS);
    chk(ev_n > 0 && ev_cyc[0] >= PAUSE_CYC && ev_cyc[0] <= PAUSE_CYC + 4, "R2",
        "first command cycle", ev_n > 0 ? ev_cyc[0] : -1, PAUSE_CYC + 3);
    chk(!cke_bad, "R3", "cke held", cke_bad, 0);
    chk(!dqm_bad, "R3", "dqm versus init_done", dqm_bad, 0);
    if (ev_n >= N_CMDS) begin
      chk(ev_cmd[0] == exp_cmd(0), "R4", "precharge code", ev_cmd[0], exp_cmd(0));
      chk(ev_addr[0] == exp_addr(0, mode_word), "R4", "precharge addr", ev_addr[0], exp_addr(0, mode_word));
      chk(ev_cmd[1] == exp_cmd(1), "R5", "mode set code", ev_cmd[1], exp_cmd(1));
      chk(ev_addr[1] == mode_word, "R5", "mode set addr", ev_addr[1], mode_word);
      chk(ev_cyc[1] - ev_cyc[0] == exp_gap(1), "R5", "precharge->mode gap", ev_cyc[1] - ev_cyc[0], exp_gap(1));
      chk(!mode_not_idle, "R6", "idle after mode set", mode_not_idle, 0);
      chk(ev_cyc[2] - ev_cyc[1] == exp_gap(2), "R6", "mode->refresh gap", ev_cyc[2] - ev_cyc[1], exp_gap(2));
      ref_bad = 0;
      for (int i = 2; i < N_CMDS; i++) begin
        if (ev_cmd[i] != exp_cmd(i) || ev_addr[i] != exp_addr(i, mode_word)) ref_bad++;
        if (i > 2 && ev_cyc[i] - ev_cyc[i-1] != exp_gap(i)) ref_bad++;
      end
      chk(ref_bad == 0, "R7", "refresh code/addr/spacing errors", ref_bad, 0);
      chk(done_cyc - ev_cyc[N_CMDS-1] == T_RFC, "R8", "ready delay after last refresh",
          done_cyc - ev_cyc[N_CMDS-1], T_RFC);
    end
    chk(init_done && !done_fell, "R9", "init_done sticky", done_fell, 0);
    chk(!cmd_after_done && !sd_dqm, "R9", "bus quiet after ready", cmd_after_done, 0);
  endtask

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      errors++; checks++;
      $display("FAIL R8 watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    // run 1: plain start-up with a random mode word
    apply_reset();
    full_run();
    // run 2: abort mid-sequence at a random command position, then full restart
    apply_reset();
    begin
      int stop_at;
      stop_at = $urandom_range(1, N_CMDS - 1);
      while (ev_n < stop_at) @(negedge clk);
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    mon_on = 0;
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state("R10");
    apply_reset();
    full_run();
    chk(ev_n == N_CMDS, "R10", "full sequence after abort", ev_n, N_CMDS);
    // run 3: all-ones mode word corner case
    apply_reset();
    mode_word = '1;
    full_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule